// File: doc/BRIEF.md
# Configurable Quadrature Edge Decoder

This block turns two asynchronous position signals, called channel A and channel B, into single-cycle step pulses for a downstream up/down counter. Each channel is brought into the clock domain by a chain of flip-flops. The block then detects its rising and falling edges by comparing the newest synchronised sample with the one before it. A two-bit edge selector chooses which edge types count: rising only, falling only, both, or none. In quadrature mode the direction of each step depends on three things: which channel moved, whether the edge was rising or falling, and the level of the other channel.

Both-edges quadrature gives four steps per full signal period. A plain counting mode is also provided. In that mode only channel A is used, every selected edge on A produces an up step, and channel B is ignored. If both channels change in the same sampled cycle while quadrature mode is on, the direction cannot be known. No step is issued in that case and an error strobe pulses instead. An enable input suppresses all outputs. Edge history keeps tracking while the block is disabled.

Top module: `qdec_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cnt_up`, `cnt_dn` and `seq_err` are all low.
- R2: With `edge_sel`=0 (rising only) and quadrature mode on, a rising edge of A produces a down step if B is high and an up step if B is low; falling edges of A produce nothing.
- R3: With `edge_sel`=0 and quadrature mode on, a rising edge of B produces an up step if A is high and a down step if A is low; falling edges of B produce nothing.
- R4: With `edge_sel`=1 (falling only) and quadrature mode on, a falling edge of A produces an up step if B is high and a down step if B is low; rising edges of A produce nothing.
- R5: With `edge_sel`=1 and quadrature mode on, a falling edge of B produces a down step if A is high and an up step if A is low; rising edges of B produce nothing.
- R6: With `edge_sel`=2 (both) and quadrature mode on, the rising rules of R2/R3 and the falling rules of R4/R5 all apply, so every single-channel edge yields one step.
- R7: With `edge_sel`=3 no up or down step is ever produced.
- R8: With `quad_mode` low, each selected edge of A gives an up step; `cnt_dn` and `seq_err` stay low, and edges of B have no effect.
- R9: In quadrature mode, if A and B change in the same synchronised cycle, no step is produced and `seq_err` is high for exactly one cycle.
- R10: At most one of `cnt_up`, `cnt_dn`, `seq_err` is high in any cycle, and each qualifying edge gives exactly one one-cycle pulse.
- R11: While `en` is low all three outputs stay low; edges seen while disabled are absorbed, so raising `en` afterwards produces no pulse.
- R12: A level change applied to an input between clock edges appears as a pulse in the cycle that follows the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Output enable; history tracks regardless |
| quad_mode | input | 1 | 1 = quadrature decoding, 0 = count edges of A only |
| edge_sel | input | 2 | 0 rising, 1 falling, 2 both, 3 none |
| in_a | input | 1 | Channel A, asynchronous |
| in_b | input | 1 | Channel B, asynchronous |
| cnt_up | output | 1 | One-cycle up step |
| cnt_dn | output | 1 | One-cycle down step |
| seq_err | output | 1 | One-cycle strobe for a simultaneous A/B change |

## Verification
The two functions that can meet in one cycle are the direction decoder of channel A and that of channel B. A simultaneous change would send them opposite or duplicate steps. The bench provokes this by driving A and B to new levels at the same instant, in both quadrature and plain modes. In quadrature mode it expects only the error strobe, at the normal latency. In plain mode it expects only the up step caused by A. A scoreboard compares every cycle against these expectations, so any extra or missing step, or a step in the wrong cycle, is reported against the requirement of the stimulus that caused it.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic up;
        logic down;
        logic err;
    } step_t;

    localparam step_t STEP_IDLE = '{up: 1'b0, down: 1'b0, err: 1'b0};

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];

    initial begin
        a_stages_r12: assert (STAGES >= 2);
    end
endmodule

// File: rtl/qdec_edge.sv
module qdec_edge #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lvl,
    output logic [NCH-1:0] rise,
    output logic [NCH-1:0] fall
);
    logic [NCH-1:0] hist_d;
    logic [NCH-1:0] hist_q;

    // History always follows the sampled level, enable or not (R11).
    always_comb begin
        hist_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign rise[i] =  lvl[i] & ~hist_q[i];
        assign fall[i] = ~lvl[i] &  hist_q[i];
    end
endmodule

// File: rtl/qdec_dir.sv
module qdec_dir
    import qdec_pkg::*;
(
    input  logic [1:0] rise,
    input  logic [1:0] fall,
    input  logic [1:0] lvl,
    input  logic [1:0] sel,
    input  logic       quad,
    output step_t      step
);
    localparam int CH_A = 0;
    localparam int CH_B = 1;

    logic act_r, act_f, moved_a, moved_b;

    always_comb begin
        act_r   = (sel == EDGE_RISE) || (sel == EDGE_BOTH);
        act_f   = (sel == EDGE_FALL) || (sel == EDGE_BOTH);
        moved_a = rise[CH_A] | fall[CH_A];
        moved_b = rise[CH_B] | fall[CH_B];
        step    = STEP_IDLE;
        if (!quad) begin
            step.up = (rise[CH_A] & act_r) | (fall[CH_A] & act_f);
        end else if (moved_a && moved_b) begin
            step.err = 1'b1;
        end else if (rise[CH_A] && act_r) begin
            step.down = lvl[CH_B];
            step.up   = ~lvl[CH_B];
        end else if (fall[CH_A] && act_f) begin
            step.up   = lvl[CH_B];
            step.down = ~lvl[CH_B];
        end else if (rise[CH_B] && act_r) begin
            step.up   = lvl[CH_A];
            step.down = ~lvl[CH_A];
        end else if (fall[CH_B] && act_f) begin
            step.down = lvl[CH_A];
            step.up   = ~lvl[CH_A];
        end
    end

    always_comb begin
        a_dir_excl_r10: assert (!(step.up && step.down));
    end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       quad_mode,
    input  logic [1:0] edge_sel,
    input  logic       in_a,
    input  logic       in_b,
    output logic       cnt_up,
    output logic       cnt_dn,
    output logic       seq_err
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw;
    logic [NCH-1:0] lvl;
    logic [NCH-1:0] rise;
    logic [NCH-1:0] fall;
    step_t          dec;

    typedef struct packed {
        step_t out;
    } state_t;

    state_t st_d, st_q;

    assign raw = {in_b, in_a};

    for (genvar i = 0; i < NCH; i++) begin : g_sync
        qdec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .dout (lvl[i])
        );
    end

    qdec_edge #(.NCH(NCH)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    qdec_dir u_dir (
        .rise (rise),
        .fall (fall),
        .lvl  (lvl),
        .sel  (edge_sel),
        .quad (quad_mode),
        .step (dec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.out = en ? dec : STEP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{out: STEP_IDLE};
        else        st_q <= st_d;
    end

    assign cnt_up  = st_q.out.up;
    assign cnt_dn  = st_q.out.down;
    assign seq_err = st_q.out.err;

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_up, cnt_dn, seq_err}));

    p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !(cnt_up || cnt_dn || seq_err));

    p_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(quad_mode) |-> !(cnt_dn || seq_err));

    p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_sel) == EDGE_NONE) |-> !(cnt_up || cnt_dn));

    p_reset_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> !(cnt_up || cnt_dn || seq_err));
endmodule

// File: tb/sim_qdec_top.sv
module sim_qdec_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       quad_mode = 1'b1;
    logic [1:0] edge_sel = 2'd0;
    logic       in_a = 1'b0;
    logic       in_b = 1'b0;
    logic       cnt_up, cnt_dn, seq_err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    string cur_tag = "R1";

    int         q_cyc[$];
    logic [2:0] q_val[$];
    string      q_tag[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qdec_top u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .quad_mode(quad_mode),
        .edge_sel(edge_sel), .in_a(in_a), .in_b(in_b),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn), .seq_err(seq_err)
    );

    // Expected {up, down, err} from the requirement table.
    function automatic logic [2:0] model(logic oa, logic ob, logic na, logic nb,
                                         logic [1:0] sel, logic quad, logic ena);
        logic ra, fa, rb, fb, ar, af;
        logic u, d, e;
        ra = !oa && na; fa = oa && !na;
        rb = !ob && nb; fb = ob && !nb;
        ar = (sel == 2'd0) || (sel == 2'd2);
        af = (sel == 2'd1) || (sel == 2'd2);
        u = 0; d = 0; e = 0;
        if (!ena) return 3'b000;
        if (!quad) u = (ra && ar) || (fa && af);
        else if ((oa != na) && (ob != nb)) e = 1;
        else if (ra && ar) begin d = ob;  u = !ob; end
        else if (fa && af) begin u = ob;  d = !ob; end
        else if (rb && ar) begin u = oa;  d = !oa; end
        else if (fb && af) begin d = oa;  u = !oa; end
        return {u, d, e};
    endfunction

    // Driver: change inputs between edges, predict the pulse three edges later (R12).
    task automatic step(input logic na, input logic nb, input string tag);
        logic [2:0] exp;
        @(negedge clk);
        exp = model(in_a, in_b, na, nb, edge_sel, quad_mode, en);
        cur_tag = tag;
        if (exp != 3'b000) begin
            q_cyc.push_back(cyc + 3);
            q_val.push_back(exp);
            q_tag.push_back(tag);
        end
        in_a = na;
        in_b = nb;
        repeat (5) @(negedge clk);
    endtask

    task automatic walk(input string ta, input string tb);
        step(1, 0, ta); step(1, 1, tb); step(0, 1, ta); step(0, 0, tb);
        step(0, 1, tb); step(1, 1, ta); step(1, 0, tb); step(0, 0, ta);
    endtask

    // Monitor: every cycle compared against the scoreboard (R10, R12).
    always @(negedge clk) begin
        if (mon_on && !done) begin
            logic [2:0] got, exp;
            string t;
            got = {cnt_up, cnt_dn, seq_err};
            exp = 3'b000;
            t = cur_tag;
            if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
                fails++;
                checks++;
                $display("FAIL %s R12: pulse missing at cycle %0d, actual=none expected=%b",
                         q_tag[0], q_cyc[0], q_val[0]);
                void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
            end
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                exp = q_val.pop_front();
                t = q_tag.pop_front();
                void'(q_cyc.pop_front());
            end
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s R10: cycle %0d actual=%b expected=%b (up,dn,err)",
                         t, cyc, got, exp);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if ({cnt_up, cnt_dn, seq_err} !== 3'b000) begin
            fails++;
            $display("FAIL R1: in reset actual=%b expected=000", {cnt_up, cnt_dn, seq_err});
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);

        quad_mode = 1'b1;
        edge_sel = 2'd0; walk("R2", "R3");
        edge_sel = 2'd1; walk("R4", "R5");
        edge_sel = 2'd2; walk("R6", "R6");
        edge_sel = 2'd3; walk("R7", "R7");

        quad_mode = 1'b0;
        for (int s = 0; s < 3; s++) begin
            edge_sel = 2'(s);
            walk("R8", "R8");
            step(1, 1, "R8"); step(0, 0, "R8");
        end

        quad_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            edge_sel = 2'(s);
            step(1, 1, "R9"); step(0, 0, "R9");
            step(1, 0, "R9"); step(0, 1, "R9"); step(0, 0, "R9");
        end

        edge_sel = 2'd2;
        @(negedge clk); en = 1'b0;
        step(1, 0, "R11"); step(1, 1, "R11"); step(0, 0, "R11");
        step(0, 1, "R11");
        @(negedge clk); en = 1'b1; cur_tag = "R11";
        repeat (6) @(negedge clk);
        step(1, 1, "R11"); step(0, 1, "R11");

        repeat (6) @(negedge clk);
        checks++;
        if (q_cyc.size() != 0) begin
            fails++;
            $display("FAIL R10: pending pulses actual=%0d expected=0", q_cyc.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule